// File: doc/BRIEF.md
# Vector Predicated Branch-Condition Sequencer

The block decides a single branch across a vector of 4-bit condition fields. A 128-entry condition field file sits inside the block and is loaded through a simple write port. A start pulse supplies the following:

- a vector length of 0 to 64;
- a 64-bit predicate mask;
- a 5-bit bit-select field;
- a 5-bit option field;
- six mode bits: all-reduce, zero-substitute enable, substitute value, length-truncate, truncate-inclusive and link-on-taken.

After the start pulse, the sequencer visits the elements in ascending order, one per clock. It combines their pass values by AND or OR, and it stops at the first element that decides the outcome.

When the scan ends, the block raises a one-cycle done pulse. With that pulse it presents four results: the taken flag, a vector length that may be truncated, the number of unmasked elements processed (used as the count-register decrement), and a link-register write enable. These results stay on the outputs until the next scan finishes. A start that arrives while a scan is running is dropped.

Top module: `vbc_seq`

## Requirements
- R1: Element i reads the condition field at index (16*bsel_i[4:2] + i) mod 128 and tests bit bsel_i[1:0] of it, where bit 0 is the LSB of the written 4-bit value.
- R2: An element passes when bopt_i[4] is 1, or when its tested bit equals bopt_i[3]. Bits [2:0] of bopt_i have no effect.
- R3: With all_i=1, the result starts true and is the AND of the element passes. The first failing element ends the scan and the branch is not taken.
- R4: With all_i=0, the result starts false and is the OR of the element passes. The first passing element ends the scan and the branch is taken.
- R5: An element whose predicate bit is 0 is skipped entirely when sz_i=0. When sz_i=1, its tested bit is replaced by snz_i.
- R6: With vlset_i=1, the first tested element that fails ends the scan and sets vl_o to its index plus vli_i. In every other case vl_o equals vl_i.
- R7: lr_we_o pulses with done_o. With lru_i=1 it pulses only when the branch is taken. With lru_i=0 it pulses on every completion.
- R8: dec_o equals the number of elements with predicate bit 1 that were tested before the scan stopped. Elements after the exit point are never counted.
- R9: The scan processes one element per cycle. done_o is high for exactly one cycle and is visible k+1 clock edges after the accepting edge, where k is the index of the last element visited. With vl_i=0, done_o is visible right after the accepting edge, taken_o equals all_i and dec_o is 0.
- R10: A start_i pulse while busy_o is high is ignored and does not change the result of the running scan.
- R11: After reset, busy_o, done_o, taken_o, vl_o, dec_o and lr_we_o are 0, and every condition field reads as 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cf_we_i | input | 1 | Condition field write enable |
| cf_waddr_i | input | 7 | Condition field write index |
| cf_wdata_i | input | 4 | Condition field write data |
| start_i | input | 1 | Start a scan (ignored while busy) |
| vl_i | input | 7 | Vector length, 0..64 |
| pmask_i | input | 64 | Predicate mask, bit i for element i |
| bsel_i | input | 5 | Field group [4:2] and bit within the field [1:0] |
| bopt_i | input | 5 | [4] force pass, [3] expected bit value, [2:0] unused |
| all_i | input | 1 | 1: AND reduction, 0: OR reduction |
| sz_i | input | 1 | Substitute masked-out elements instead of skipping them |
| snz_i | input | 1 | Value substituted for masked-out elements |
| vlset_i | input | 1 | Truncate the vector length at the first failure |
| vli_i | input | 1 | Truncation includes the failing element |
| lru_i | input | 1 | Write the link register only when taken |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision, held |
| vl_o | output | 7 | Resulting vector length, held |
| dec_o | output | 7 | Count-register decrement, held |
| lr_we_o | output | 1 | Link-register write enable, pulses with done_o |

## Verification
Every result is due on a fixed edge. A scan that is accepted on one edge and stops at element k raises done_o on edge k+1 with all of its results. An empty vector completes on the accepting edge itself. The bench counts clock edges from the accepting edge and samples at the falling edge that follows each rising edge. It compares that count with the exit position taken from its own model, and it samples the held results and the link enable in the cycle where done_o is high. It then samples one cycle later to confirm that done_o has dropped.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef struct packed {
    logic       all;
    logic       sz;
    logic       snz;
    logic       vlset;
    logic       vli;
    logic       lru;
    logic       force_pass;
    logic       expect_one;
    logic [2:0] grp;
    logic [1:0] bit_sel;
  } cfg_t;
endpackage

// File: rtl/vbc_cf_file.sv
module vbc_cf_file #(
  parameter int NFIELD = 128,
  parameter int FW     = 4,
  localparam int AW    = $clog2(NFIELD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [FW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [FW-1:0] rdata_o
);
  logic [FW-1:0] mem_q [NFIELD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFIELD; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/vbc_elem_eval.sv
module vbc_elem_eval #(
  parameter int FW = 4
) (
  input  logic          pred_i,
  input  logic [FW-1:0] field_i,
  input  vbc_pkg::cfg_t cfg_i,
  output logic          skip_o,
  output logic          pass_o
);
  logic tbit;

  assign tbit   = pred_i ? field_i[cfg_i.bit_sel] : cfg_i.snz;
  assign skip_o = !pred_i && !cfg_i.sz;
  assign pass_o = cfg_i.force_pass || (tbit == cfg_i.expect_one);
endmodule

// File: rtl/vbc_scan_ctrl.sv
module vbc_scan_ctrl #(
  parameter int VL_MAX = 64,
  localparam int VLW   = $clog2(VL_MAX + 1),
  localparam int PW    = $clog2(VL_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [VL_MAX-1:0] pmask_i,
  input  vbc_pkg::cfg_t     cfg_i,
  input  logic              skip_i,
  input  logic              pass_i,
  output vbc_pkg::cfg_t     cfg_o,
  output logic [VLW-1:0]    idx_o,
  output logic              pred_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [VLW-1:0]    vl_o,
  output logic [VLW-1:0]    dec_o,
  output logic              lr_we_o
);
  vbc_pkg::cfg_t     cfg_q;
  logic [VL_MAX-1:0] pmask_q;
  logic [VLW-1:0]    vl_q, idx_q, cnt_q, vlo_q, dec_q;
  logic              busy_q, done_q, acc_q, taken_q, lr_q;

  logic           last, acc_n, exit_hit, vfail, stop;
  logic [VLW-1:0] cnt_n, vl_new;

  assign pred_o = pmask_q[idx_q[PW-1:0]];
  assign last   = (idx_q + VLW'(1)) == vl_q;

  always_comb begin
    cnt_n    = cnt_q;
    acc_n    = acc_q;
    exit_hit = 1'b0;
    vfail    = 1'b0;
    if (!skip_i) begin
      cnt_n    = cnt_q + VLW'(pred_o);
      acc_n    = cfg_q.all ? (acc_q & pass_i) : (acc_q | pass_i);
      exit_hit = cfg_q.all ? !pass_i : pass_i;
      vfail    = cfg_q.vlset && !pass_i;
    end
    stop   = exit_hit || vfail || last;
    vl_new = vfail ? idx_q + VLW'(cfg_q.vli) : vl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      pmask_q <= '0;
      vl_q    <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      vlo_q   <= '0;
      dec_q   <= '0;
      lr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      lr_q   <= 1'b0;
      if (busy_q) begin
        idx_q <= idx_q + VLW'(1);
        cnt_q <= cnt_n;
        acc_q <= acc_n;
        if (stop) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          taken_q <= acc_n;
          vlo_q   <= vl_new;
          dec_q   <= cnt_n;
          lr_q    <= !cfg_q.lru || acc_n;
        end
      end else if (start_i) begin
        cfg_q   <= cfg_i;
        pmask_q <= pmask_i;
        vl_q    <= vl_i;
        idx_q   <= '0;
        cnt_q   <= '0;
        acc_q   <= cfg_i.all;
        if (vl_i == '0) begin
          done_q  <= 1'b1;
          taken_q <= cfg_i.all;
          vlo_q   <= '0;
          dec_q   <= '0;
          lr_q    <= !cfg_i.lru || cfg_i.all;
        end else begin
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign taken_o = taken_q;
  assign vl_o    = vlo_q;
  assign dec_o   = dec_q;
  assign lr_we_o = lr_q;

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r10_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !stop |=> busy_q && idx_q == $past(idx_q) + VLW'(1));
  a_r3_all_fail_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cfg_q.all && !skip_i && !pass_i |=> done_q && !taken_q);
  a_r4_any_pass_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cfg_q.all && !skip_i && pass_i |=> done_q && taken_q);
  a_r6_vl_not_grown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> vlo_q <= vl_q);
  a_r8_dec_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> dec_q <= vl_q);
  a_r7_lr_only_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && cfg_q.lru && !taken_q |-> !lr_q);
endmodule

// File: rtl/vbc_seq.sv
module vbc_seq #(
  parameter int NFIELD = 128,
  parameter int FW     = 4,
  parameter int VL_MAX = 64,
  localparam int AW    = $clog2(NFIELD),
  localparam int VLW   = $clog2(VL_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cf_we_i,
  input  logic [AW-1:0]     cf_waddr_i,
  input  logic [FW-1:0]     cf_wdata_i,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [VL_MAX-1:0] pmask_i,
  input  logic [4:0]        bsel_i,
  input  logic [4:0]        bopt_i,
  input  logic              all_i,
  input  logic              sz_i,
  input  logic              snz_i,
  input  logic              vlset_i,
  input  logic              vli_i,
  input  logic              lru_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [VLW-1:0]    vl_o,
  output logic [VLW-1:0]    dec_o,
  output logic              lr_we_o
);
  localparam int GSHIFT = AW - 3;

  vbc_pkg::cfg_t  cfg_in, cfg_run;
  logic [VLW-1:0] idx;
  logic [AW-1:0]  raddr;
  logic [FW-1:0]  field;
  logic           pred, skip, pass;
  logic           unused_opt;

  assign unused_opt = ^bopt_i[2:0];

  always_comb begin
    cfg_in            = '0;
    cfg_in.all        = all_i;
    cfg_in.sz         = sz_i;
    cfg_in.snz        = snz_i;
    cfg_in.vlset      = vlset_i;
    cfg_in.vli        = vli_i;
    cfg_in.lru        = lru_i;
    cfg_in.force_pass = bopt_i[4];
    cfg_in.expect_one = bopt_i[3];
    cfg_in.grp        = bsel_i[4:2];
    cfg_in.bit_sel    = bsel_i[1:0];
  end

  // group base plus element index, wrapping over the file
  assign raddr = (AW'(cfg_run.grp) << GSHIFT) + AW'(idx);

  vbc_cf_file #(.NFIELD(NFIELD), .FW(FW)) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cf_we_i),
    .waddr_i (cf_waddr_i),
    .wdata_i (cf_wdata_i),
    .raddr_i (raddr),
    .rdata_o (field)
  );

  vbc_elem_eval #(.FW(FW)) u_eval (
    .pred_i  (pred),
    .field_i (field),
    .cfg_i   (cfg_run),
    .skip_o  (skip),
    .pass_o  (pass)
  );

  vbc_scan_ctrl #(.VL_MAX(VL_MAX)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vl_i    (vl_i),
    .pmask_i (pmask_i),
    .cfg_i   (cfg_in),
    .skip_i  (skip),
    .pass_i  (pass),
    .cfg_o   (cfg_run),
    .idx_o   (idx),
    .pred_o  (pred),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .taken_o (taken_o),
    .vl_o    (vl_o),
    .dec_o   (dec_o),
    .lr_we_o (lr_we_o)
  );
endmodule

// File: tb/tb_vbc_seq.sv
module tb_vbc_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cf_we_i = 1'b0;
  logic [6:0]  cf_waddr_i = '0;
  logic [3:0]  cf_wdata_i = '0;
  logic        start_i = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [63:0] pmask_i = '0;
  logic [4:0]  bsel_i = '0, bopt_i = '0;
  logic        all_i = 0, sz_i = 0, snz_i = 0, vlset_i = 0, vli_i = 0, lru_i = 0;
  logic        busy_o, done_o, taken_o, lr_we_o;
  logic [6:0]  vl_o, dec_o;

  int checks = 0, errors = 0;
  logic [3:0] fm [128];

  always #4 clk_i = ~clk_i;

  vbc_seq dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int vl, input logic [63:0] pm, input logic [4:0] bs,
      input logic [4:0] bo, input logic al, sz, snz, vs, vi, lu,
      output logic tk, output int vlo, output int dec, output int lat, output logic lr);
    logic acc, t, p;
    acc = al; dec = 0; vlo = vl; lat = vl;
    for (int i = 0; i < vl; i++) begin
      if (!pm[i] && !sz) continue;
      t = pm[i] ? fm[(int'(bs[4:2]) * 16 + i) % 128][bs[1:0]] : snz;
      p = bo[4] || (t == bo[3]);
      dec += int'(pm[i]);
      acc = al ? (acc & p) : (acc | p);
      if (vs && !p) begin vlo = i + int'(vi); lat = i + 1; break; end
      if (al ? !p : p) begin lat = i + 1; break; end
    end
    tk = acc; lr = !lu || acc;
  endfunction

  task automatic run(input string tag, input int vl, input logic [63:0] pm,
      input logic [4:0] bs, input logic [4:0] bo, input logic al, sz, snz, vs, vi, lu,
      input bit poke);
    logic tk, lr; int vlo, dec, lat, n;
    model(vl, pm, bs, bo, al, sz, snz, vs, vi, lu, tk, vlo, dec, lat, lr);
    @(negedge clk_i);
    vl_i = 7'(vl); pmask_i = pm; bsel_i = bs; bopt_i = bo;
    all_i = al; sz_i = sz; snz_i = snz; vlset_i = vs; vli_i = vi; lru_i = lu;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 200) begin
      if (poke && n == 1) begin  // R10: disturb the running scan
        start_i = 1'b1; vl_i = 7'd1; all_i = ~al; bopt_i = ~bo; pmask_i = ~pm;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      n++;
    end
    chk({tag, " R9 latency"}, n, lat);
    chk({tag, " R3/R4 taken"}, int'(taken_o), int'(tk));
    chk({tag, " R6 vl"}, int'(vl_o), vlo);
    chk({tag, " R8 dec"}, int'(dec_o), dec);
    chk({tag, " R7 lr_we"}, int'(lr_we_o), int'(lr));
    @(negedge clk_i);
    chk({tag, " R9 done pulse"}, int'(done_o), 0);
    chk({tag, " R7 lr pulse"}, int'(lr_we_o), 0);
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) fm[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R11 busy", int'(busy_o), 0);
    chk("R11 done", int'(done_o), 0);
    chk("R11 taken", int'(taken_o), 0);
    chk("R11 vl", int'(vl_o), 0);
    chk("R11 dec", int'(dec_o), 0);
    chk("R11 lr", int'(lr_we_o), 0);
    rst_ni = 1'b1;
    // R11: all fields zero -> every bit tests 0; expect-0 AND over 64 passes
    run("R11 zero file", 64, '1, 5'b11111, 5'b00000, 1, 0, 0, 0, 0, 1, 0);
    // load random fields
    for (int i = 0; i < 128; i++) begin
      @(negedge clk_i);
      fm[i] = 4'($urandom);
      cf_we_i = 1'b1; cf_waddr_i = 7'(i); cf_wdata_i = fm[i];
    end
    @(negedge clk_i);
    cf_we_i = 1'b0;
    // R1: group 7 wraps past field 127
    run("R1 wrap", 40, '1, 5'b11110, 5'b01000, 1, 0, 0, 0, 0, 0, 0);
    run("R1 bit0", 20, '1, 5'b01000, 5'b00000, 0, 0, 0, 0, 0, 0, 0);
    // R2: force pass, and low option bits are don't-care
    run("R2 force", 33, '1, 5'b00101, 5'b10000, 1, 0, 0, 0, 0, 1, 0);
    run("R2 lowbits", 30, '1, 5'b00110, 5'b01111, 1, 0, 0, 0, 0, 1, 0);
    // R9: empty vectors
    run("R9 vl0 all", 0, '1, 5'b0, 5'b0, 1, 0, 0, 0, 0, 1, 0);
    run("R9 vl0 any", 0, '1, 5'b0, 5'b0, 0, 0, 0, 0, 0, 1, 0);
    // R5: all-masked vectors
    run("R5 masked skip all", 64, '0, 5'b0, 5'b0, 1, 0, 0, 0, 0, 1, 0);
    run("R5 masked skip any", 64, '0, 5'b0, 5'b0, 0, 0, 0, 0, 0, 1, 0);
    run("R5 snz0 all", 17, '0, 5'b0, 5'b01000, 1, 1, 0, 0, 0, 1, 0);
    run("R5 snz1 all", 17, '0, 5'b0, 5'b01000, 1, 1, 1, 0, 0, 1, 0);
    run("R5 snz1 any", 17, '0, 5'b0, 5'b01000, 0, 1, 1, 0, 0, 1, 0);
    // R6: truncation, inclusive and exclusive
    run("R6 vli0", 64, '1, 5'b00011, 5'b01000, 1, 0, 0, 1, 0, 0, 0);
    run("R6 vli1", 64, '1, 5'b00011, 5'b01000, 0, 0, 0, 1, 1, 0, 0);
    run("R6 snz0 cut", 50, 64'h0000_0000_00FF_FFFF, 5'b0, 5'b00000, 1, 1, 0, 1, 1, 0, 0);
    // R10: start during busy is ignored
    run("R10 poke", 64, '1, 5'b0, 5'b10000, 1, 0, 0, 0, 0, 0, 1);
    for (int t = 0; t < 400; t++) begin
      logic [63:0] pm;
      pm = {$urandom, $urandom};
      if (t % 5 == 0) pm = pm & {$urandom, $urandom};
      run("R3/R4/R5/R6 rand", int'($urandom % 65), pm, 5'($urandom), 5'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), t % 7 == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule